// File: doc/BRIEF.md
# Video line and frame timing generator

This block turns a free-running system clock into the line and frame timing of a raster display. The clock frequency is not an integer multiple of the line rate, so each line length is built by a fixed-point accumulator that has 12 fractional bits. For every line it adds a per-line increment. The integer part of the sum is the length of the next line in clocks, and the fractional part is carried forward. Over many lines the average period is therefore exact, while any single line is a whole number of clocks.

Two display standards are selectable. By default the first has 263 lines per frame and an increment of 8791293, about 2146.31 clocks per line. The second has 313 lines and an increment of 8864320, about 2164.14 clocks per line. A one-cycle line tick marks every line start. A one-cycle interrupt pulse marks the start of vertical blank at line 240, and a blank level is held until the frame wraps. A frame counter advances at every wrap. When interlacing is enabled, a field bit copies the frame counter's low bit.

The sequencing is a two-state machine. ACTIVE is the visible part of the frame. It moves to BLANK on the line end whose next line number is the blank line (transition "enter blank", which raises the interrupt). BLANK moves back to ACTIVE on the line end of the last line of the frame (transition "frame wrap", which clears the line number, counts the frame, updates the field and takes the new standard). All counts are parameters so that a bench can shorten the frame.

Top module: `vtiming_gen`

## Requirements
- R1: With `std_sel`=0 (first standard), each line length equals floor(S/4096), where S is the carried fraction plus INC_A. The fraction carried forward is S mod 4096.
- R2: With `std_sel`=1 (second standard), the same accumulation applies using INC_B.
- R3: `line_num` counts lines from 0. After the last line of a frame (LINES_A-1 or LINES_B-1 for the standard in force), it returns to 0 and `frame_num` increments by one, wrapping modulo 2^FRAME_W.
- R4: `vblank_irq` is high for exactly one cycle, the tick cycle in which `line_num` becomes VBL_LINE. It is never high otherwise.
- R5: `vblank` is 1 while `line_num` >= VBL_LINE and 0 on lines below it, so it drops when the frame wraps to line 0.
- R6: At each frame wrap, `field` takes bit 0 of the new frame count if `ilace_en` is 1 at that edge, and 0 otherwise. It changes at no other time.
- R7: `std_sel` is sampled only at a frame wrap. A change made mid-frame affects neither the line count nor the line lengths until the next frame begins.
- R8: A synchronous reset (`rst_n`=0) clears `line_num`, `frame_num`, `field`, `vblank`, `vblank_irq`, `hsync_tick` and the fraction. The first line after release is floor(INC/4096) clocks for the standard present on `std_sel` during reset.
- R9: `hsync_tick` is high for one cycle per line, in the first cycle of the new line, and `line_num` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| std_sel | input | 1 | Standard select: 0 first standard, 1 second standard |
| ilace_en | input | 1 | Interlace enable for the field bit |
| hsync_tick | output | 1 | One-cycle pulse at each line start |
| vblank_irq | output | 1 | One-cycle pulse when vertical blank begins |
| vblank | output | 1 | Vertical blank level |
| line_num | output | LINE_W | Current line within the frame |
| frame_num | output | FRAME_W | Frame counter |
| field | output | 1 | Odd/even field for interlaced output |

## Verification
The bench keeps its own model of the fraction and predicts every line length. A design that drops the carry, or that reloads the fraction at each frame, would produce ticks one clock early on some lines. Standard changes are applied just after a wrap, which is mid-frame for the new frame. A design that sampled `std_sel` at once would show a wrong line count or line length in that frame. Interlace is switched on and off between frames, and a reset is applied mid-frame with the other standard selected. These catch a field that toggles without interlace, a blank level that lingers past line 0, and a first line taken from the old standard.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
    typedef enum logic [0:0] {
        ST_ACTIVE = 1'b0,
        ST_BLANK  = 1'b1
    } vtg_state_e;
endpackage

// File: rtl/vtg_line_clock.sv
`timescale 1ns/1ps
module vtg_line_clock #(
    parameter int INC_W     = 24,
    parameter int FRAC_BITS = 12,
    localparam int LEN_W    = INC_W + 1 - FRAC_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic             line_end
);
    logic [FRAC_BITS-1:0] frac;
    logic [LEN_W-1:0]     len;
    logic [LEN_W-1:0]     cnt;
    logic [INC_W:0]       sum;

    // Reset starts the accumulation from zero fraction
    always_comb begin
        sum = {1'b0, inc};
        if (rst_n) begin
            sum = {{(INC_W + 1 - FRAC_BITS){1'b0}}, frac} + {1'b0, inc};
        end
    end

    assign line_end = (cnt == len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            len  <= sum[INC_W:FRAC_BITS];
            frac <= sum[FRAC_BITS-1:0];
        end else if (line_end) begin
            cnt  <= '0;
            len  <= sum[INC_W:FRAC_BITS];
            frac <= sum[FRAC_BITS-1:0];
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vtg_frame_seq.sv
`timescale 1ns/1ps
module vtg_frame_seq
    import vtg_pkg::*;
#(
    parameter int LINE_W   = 9,
    parameter int FRAME_W  = 16,
    parameter int LINES_A  = 263,
    parameter int LINES_B  = 313,
    parameter int VBL_LINE = 240
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_end,
    input  logic               std_sel,
    input  logic               ilace_en,
    output logic               last_line,
    output logic               std_q,
    output logic               hsync_tick,
    output logic               vblank_irq,
    output logic               vblank,
    output logic [LINE_W-1:0]  line_num,
    output logic [FRAME_W-1:0] frame_num,
    output logic               field
);
    vtg_state_e         state, state_nx;
    logic [LINE_W-1:0]  total;
    logic [LINE_W-1:0]  line_inc;
    logic [FRAME_W-1:0] frame_inc;

    assign total     = std_q ? LINE_W'(LINES_B) : LINE_W'(LINES_A);
    assign last_line = (line_num == total - 1'b1);
    assign line_inc  = line_num + 1'b1;
    assign frame_inc = frame_num + 1'b1;
    assign vblank    = (state == ST_BLANK);

    // Next state: enter blank, frame wrap
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: begin
                if (line_end && !last_line && line_inc == LINE_W'(VBL_LINE)) begin
                    state_nx = ST_BLANK;
                end
            end
            ST_BLANK: begin
                if (line_end && last_line) begin
                    state_nx = ST_ACTIVE;
                end
            end
            default: state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_tick <= 1'b0;
            vblank_irq <= 1'b0;
            line_num   <= '0;
            frame_num  <= '0;
            field      <= 1'b0;
            std_q      <= std_sel;
        end else begin
            hsync_tick <= line_end;
            vblank_irq <= (state == ST_ACTIVE) && (state_nx == ST_BLANK);
            if (line_end) begin
                if (last_line) begin
                    line_num  <= '0;
                    frame_num <= frame_inc;
                    field     <= ilace_en & frame_inc[0];
                    std_q     <= std_sel;
                end else begin
                    line_num  <= line_inc;
                end
            end
        end
    end
endmodule

// File: rtl/vtiming_gen.sv
`timescale 1ns/1ps
module vtiming_gen #(
    parameter int INC_A     = 8791293,
    parameter int INC_B     = 8864320,
    parameter int LINES_A   = 263,
    parameter int LINES_B   = 313,
    parameter int VBL_LINE  = 240,
    parameter int FRAME_W   = 16,
    parameter int INC_W     = 24,
    parameter int FRAC_BITS = 12,
    localparam int LINES_MAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
    localparam int LINE_W    = $clog2(LINES_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               std_sel,
    input  logic               ilace_en,
    output logic               hsync_tick,
    output logic               vblank_irq,
    output logic               vblank,
    output logic [LINE_W-1:0]  line_num,
    output logic [FRAME_W-1:0] frame_num,
    output logic               field
);
    logic             line_end;
    logic             last_line;
    logic             std_q;
    logic             std_pick;
    logic [INC_W-1:0] inc;

    // The new standard is used from the line that opens a frame
    assign std_pick = (last_line || !rst_n) ? std_sel : std_q;
    assign inc      = std_pick ? INC_W'(INC_B) : INC_W'(INC_A);

    vtg_line_clock #(
        .INC_W     (INC_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_lclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .line_end (line_end)
    );

    vtg_frame_seq #(
        .LINE_W   (LINE_W),
        .FRAME_W  (FRAME_W),
        .LINES_A  (LINES_A),
        .LINES_B  (LINES_B),
        .VBL_LINE (VBL_LINE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .std_sel    (std_sel),
        .ilace_en   (ilace_en),
        .last_line  (last_line),
        .std_q      (std_q),
        .hsync_tick (hsync_tick),
        .vblank_irq (vblank_irq),
        .vblank     (vblank),
        .line_num   (line_num),
        .frame_num  (frame_num),
        .field      (field)
    );
endmodule

// File: rtl/vtg_checker.sv
`timescale 1ns/1ps
module vtg_checker #(
    parameter int LINE_W    = 9,
    parameter int FRAME_W   = 16,
    parameter int VBL_LINE  = 240,
    parameter int LINES_MAX = 313
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hsync_tick,
    input logic               vblank_irq,
    input logic               vblank,
    input logic [LINE_W-1:0]  line_num,
    input logic [FRAME_W-1:0] frame_num,
    input logic               field
);
    assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_tick |=> !hsync_tick);

    assert_line_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_num) |-> hsync_tick);

    assert_irq_at_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (hsync_tick && int'(line_num) == VBL_LINE));

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq);

    assert_blank_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vblank == (int'(line_num) >= VBL_LINE));

    assert_frame_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_num) |-> (hsync_tick && line_num == '0));

    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(line_num) < LINES_MAX);

    assert_field_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> (hsync_tick && line_num == '0));
endmodule

bind vtiming_gen vtg_checker #(
    .LINE_W    (LINE_W),
    .FRAME_W   (FRAME_W),
    .VBL_LINE  (VBL_LINE),
    .LINES_MAX (LINES_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_tick (hsync_tick),
    .vblank_irq (vblank_irq),
    .vblank     (vblank),
    .line_num   (line_num),
    .frame_num  (frame_num),
    .field      (field)
);

// File: tb/vtiming_gen_test.sv
`timescale 1ns/1ps
module vtiming_gen_test;
    localparam int TA_INC   = 21709;
    localparam int TB_INC   = 28076;
    localparam int TA_LINES = 7;
    localparam int TB_LINES = 9;
    localparam int T_VBL    = 4;
    localparam int FW       = 8;
    localparam int LW       = $clog2(TB_LINES);
    localparam int NVEC     = 6;
    // {std_sel, ilace_en, frames to run}
    localparam bit [5:0] VEC [0:NVEC-1] = '{
        6'b0_0_0010, 6'b0_1_0011, 6'b1_1_0010,
        6'b1_0_0001, 6'b0_1_0010, 6'b1_0_0001
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          std_sel = 1'b0;
    logic          ilace_en = 1'b0;
    logic          hsync_tick, vblank_irq, vblank, field;
    logic [LW-1:0] line_num;
    logic [FW-1:0] frame_num;

    int n_chk = 0;
    int n_fail = 0;
    int m_frac, m_len, m_line, m_frame, m_std, m_field;

    always #2 clk = ~clk;

    vtiming_gen #(
        .INC_A (TA_INC), .INC_B (TB_INC), .LINES_A (TA_LINES),
        .LINES_B (TB_LINES), .VBL_LINE (T_VBL), .FRAME_W (FW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .std_sel (std_sel), .ilace_en (ilace_en),
        .hsync_tick (hsync_tick), .vblank_irq (vblank_irq), .vblank (vblank),
        .line_num (line_num), .frame_num (frame_num), .field (field)
    );

    function automatic int inc_of(int s);
        return (s != 0) ? TB_INC : TA_INC;
    endfunction

    function automatic int lines_of(int s);
        return (s != 0) ? TB_LINES : TA_LINES;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        int sum;
        sum     = inc_of(int'(std_sel));
        m_len   = sum >> 12;
        m_frac  = sum & 4095;
        m_line  = 0;
        m_frame = 0;
        m_std   = int'(std_sel);
        m_field = 0;
    endtask

    task automatic check_reset_state();
        check("R8 line", int'(line_num), 0);
        check("R8 frame", int'(frame_num), 0);
        check("R8 vblank", int'(vblank), 0);
        check("R8 irq", int'(vblank_irq), 0);
        check("R8 tick", int'(hsync_tick), 0);
        check("R8 field", int'(field), 0);
    endtask

    task automatic run_line();
        int cnt = 0;
        int stray = 0;
        int sum;
        bit wrap;
        string lt;
        if (int'(std_sel) != m_std) lt = "R7 length";
        else if (m_std != 0) lt = "R2 length";
        else lt = "R1 length";
        do begin
            @(negedge clk);
            cnt++;
            if (vblank_irq && !hsync_tick) stray = 1;
        end while (!hsync_tick && cnt < 1000);
        check(lt, cnt, m_len);
        wrap = (m_line + 1 == lines_of(m_std));
        sum  = m_frac + inc_of(wrap ? int'(std_sel) : m_std);
        m_len  = sum >> 12;
        m_frac = sum & 4095;
        if (wrap) begin
            m_line  = 0;
            m_frame = (m_frame + 1) % (1 << FW);
            m_std   = int'(std_sel);
            m_field = int'(ilace_en) & (m_frame & 1);
        end else begin
            m_line++;
        end
        check("R9 line", int'(line_num), m_line);
        check("R3 frame", int'(frame_num), m_frame);
        check("R5 vblank", int'(vblank), (m_line >= T_VBL) ? 1 : 0);
        check("R4 irq", int'(vblank_irq), (m_line == T_VBL) ? 1 : 0);
        check("R4 stray irq", stray, 0);
        check("R6 field", int'(field), m_field);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        model_reset();
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            int wraps = 0;
            std_sel  = VEC[v][5];
            ilace_en = VEC[v][4];
            while (wraps < int'(VEC[v][3:0])) begin
                run_line();
                if (m_line == 0) wraps++;
            end
        end

        // Mid-frame change of standard must wait for the wrap (R7)
        run_line();
        run_line();
        std_sel = ~std_sel;
        while (m_line != 0) run_line();
        run_line();

        // Reset mid-frame with the other standard selected (R8)
        std_sel  = ~std_sel;
        ilace_en = 1'b1;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        model_reset();
        rst_n = 1'b1;
        for (int k = 0; k < 2 * TB_LINES + 3; k++) run_line();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule